// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This unit produces the instruction fetch address for a small core with 12-bit instruction words. It keeps a program counter whose width is a parameter (9, 10 or 11 bits). Every cycle it either steps the counter by one or loads it. A load comes from one of four sources: a jump literal, a call literal, an ALU result written to the counter's low byte, or the top of a two-entry return-address stack. Where a load needs address bits above bit 8, those bits come from a two-bit page-select input driven by the core's status register. Stepping past the end of a page therefore carries into the next page, but the page-select value stays as it was.

The stack has two levels, and each level is as wide as the counter. A call pushes the return address and discards the older entry. A return copies level 2 into level 1 and leaves level 2 as it was, so repeated returns keep producing the same address. A return also hands its 8-bit literal to the working register. Decode, the ALU, program memory and page-select storage are outside this block.

Top module: `pcu_top`

## Requirements
- R1: While `rst_n` is low the fetch address is all ones, which is the reset vector. Both stack levels are cleared, so a return as the first operation after reset goes to address 0.
- R2: Operation code 0 (step), and any code above 4, loads the counter with the current address plus one. The sum wraps modulo 2^PC_W and carries across page boundaries, so 0x1FF steps to 0x200.
- R3: Operation code 1 (jump) loads address bits 8:0 from `lit_i[8:0]`. Bits 10:9 are loaded from `page_i[1:0]`.
- R4: Operation code 2 (call) loads bits 7:0 from `lit_i[7:0]`, clears bit 8 and loads bits 10:9 from `page_i`.
- R5: Operation code 3 (low-byte write) loads bits 7:0 from `alu_i`, clears bit 8 and loads bits 10:9 from `page_i`.
- R6: The upper address bits of every load come only from `page_i`. After a step from 0x1FF to 0x200, a jump with `page_i` = 0 lands in page 0.
- R7: A call moves stack level 1 into level 2 and writes the current address plus one into level 1.
- R8: After three nested calls, only the two most recent return addresses remain.
- R9: Operation code 4 (return) loads the counter from level 1 and copies level 2 into level 1. Level 2 keeps its value, so a third return after two calls repeats the second return's address.
- R10: `wreg_we_o` is high exactly in the cycles where the operation is a return, and in those cycles `wreg_lit_o` equals `lit_i[7:0]`.
- R11: With PC_W = 10 a jump uses only `page_i[0]` for bit 9, and `page_i[1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op_i | input | 3 | Decoded address operation: 0 step, 1 jump, 2 call, 3 low-byte write, 4 return |
| lit_i | input | 9 | Literal field of the current instruction |
| alu_i | input | 8 | ALU result for a low-byte write |
| page_i | input | 2 | Page-select bits from the status register |
| fetch_addr_o | output | PC_W | Registered fetch address |
| wreg_lit_o | output | 8 | Literal returned to the working register |
| wreg_we_o | output | 1 | Working-register load strobe on a return |

## Verification
The bench steps from 0x1FF into 0x200 and then jumps with clear page bits. A design that took the upper bits from the counter would stay in page 1 instead of landing in page 0. It nests three calls and then returns three times. A stack that shifted zeros into level 2 on a pop, or that kept the oldest entry on overflow, would return to the wrong address on the second or third return. It also checks the reset vector, a return straight after reset (which must go to 0 from the cleared stack), the forced-low bit 8 on calls and low-byte writes, and that a 10-bit instance ignores `page_i[1]`.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_LOWWR = 3'd3,
    OP_RET   = 3'd4
  } pcu_op_e;

  localparam int LIT_W  = 9;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 2;

  // Codes without an operation of their own act as a plain step.
  function automatic pcu_op_e pcu_decode(input logic [2:0] code);
    pcu_op_e r;
    case (code)
      3'd1:    r = OP_JUMP;
      3'd2:    r = OP_CALL;
      3'd3:    r = OP_LOWWR;
      3'd4:    r = OP_RET;
      default: r = OP_STEP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  pcu_op_e             op,
  input  logic [LIT_W-1:0]    lit,
  input  logic [BYTE_W-1:0]   alu,
  input  logic [PAGE_W-1:0]   page,
  input  logic [PC_W-1:0]     pc_inc,
  input  logic [PC_W-1:0]     top_of_stack,
  output logic [PC_W-1:0]     pc_next
);

  localparam int PG_USED = PC_W - LIT_W;

  logic [LIT_W-1:0] jump_lo;
  logic [LIT_W-1:0] call_lo;
  logic [LIT_W-1:0] wr_lo;
  logic [PC_W-1:0]  jump_tgt;
  logic [PC_W-1:0]  call_tgt;
  logic [PC_W-1:0]  wr_tgt;

  // Calls and low-byte writes reach only the first half of a page.
  assign jump_lo = lit;
  assign call_lo = {1'b0, lit[BYTE_W-1:0]};
  assign wr_lo   = {1'b0, alu};

  generate
    if (PG_USED > 0) begin : g_paged
      logic [PG_USED-1:0] pg;
      assign pg       = page[PG_USED-1:0];
      assign jump_tgt = {pg, jump_lo};
      assign call_tgt = {pg, call_lo};
      assign wr_tgt   = {pg, wr_lo};
    end else begin : g_flat
      logic unused_page;
      assign unused_page = ^page;
      assign jump_tgt    = jump_lo;
      assign call_tgt    = call_lo;
      assign wr_tgt      = wr_lo;
    end
  endgenerate

  always_comb begin
    pc_next = pc_inc;
    case (op)
      OP_JUMP:  pc_next = jump_tgt;
      OP_CALL:  pc_next = call_tgt;
      OP_LOWWR: pc_next = wr_tgt;
      OP_RET:   pc_next = top_of_stack;
      default:  pc_next = pc_inc;
    endcase
  end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_val,
  output logic [PC_W-1:0] lvl1,
  output logic [PC_W-1:0] lvl2
);

  logic [PC_W-1:0] lvl1_d;
  logic [PC_W-1:0] lvl2_d;
  logic            lvl1_en;
  logic            lvl2_en;

  // On a push level 2 takes level 1 and the oldest entry is lost.
  // On a pop level 1 takes level 2 and level 2 holds its value.
  assign lvl1_en = push | pop;
  assign lvl2_en = push;

  always_comb begin
    lvl1_d = lvl1;
    lvl2_d = lvl2;
    if (push) begin
      lvl1_d = push_val;
      lvl2_d = lvl1;
    end else if (pop) begin
      lvl1_d = lvl2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl1 <= '0;
    end else if (lvl1_en) begin
      lvl1 <= lvl1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl2 <= '0;
    end else if (lvl2_en) begin
      lvl2 <= lvl2_d;
    end
  end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic [LIT_W-1:0]    lit_i,
  input  logic [BYTE_W-1:0]   alu_i,
  input  logic [PAGE_W-1:0]   page_i,
  output logic [PC_W-1:0]     fetch_addr_o,
  output logic [BYTE_W-1:0]   wreg_lit_o,
  output logic                wreg_we_o
);

  localparam logic [PC_W-1:0] RESET_VEC = '1;
  localparam logic [PC_W-1:0] PC_ONE    = PC_W'(1);

  pcu_op_e         op;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] lvl1;
  logic [PC_W-1:0] lvl2;
  logic            do_push;
  logic            do_pop;

  assign op      = pcu_decode(op_i);
  assign pc_inc  = pc_q + PC_ONE;
  assign do_push = (op == OP_CALL);
  assign do_pop  = (op == OP_RET);

  pcu_target #(.PC_W(PC_W)) u_target (
    .op           (op),
    .lit          (lit_i),
    .alu          (alu_i),
    .page         (page_i),
    .pc_inc       (pc_inc),
    .top_of_stack (lvl1),
    .pc_next      (pc_d)
  );

  pcu_stack #(.PC_W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_push),
    .pop      (do_pop),
    .push_val (pc_inc),
    .lvl1     (lvl1),
    .lvl2     (lvl2)
  );

  // The counter loads every cycle; the enable is kept for structure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
    end else if (1'b1) begin
      pc_q <= pc_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign wreg_we_o    = do_pop;
  assign wreg_lit_o   = lit_i[BYTE_W-1:0];

endmodule

// File: rtl/pcu_top_chk.sv
module pcu_top_chk #(
  parameter int PC_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_i,
  input logic [8:0]      lit_i,
  input logic [7:0]      alu_i,
  input logic [1:0]      page_i,
  input logic [PC_W-1:0] fetch_addr_o,
  input logic [7:0]      wreg_lit_o,
  input logic            wreg_we_o,
  input logic [PC_W-1:0] lvl1,
  input logic [PC_W-1:0] lvl2
);

  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [10:0]     jmp_full;
  logic [10:0]     cal_full;
  logic [10:0]     wr_full;
  logic [PC_W-1:0] inc_c;
  logic            is_step;

  assign jmp_full = {page_i, lit_i};
  assign cal_full = {page_i, 1'b0, lit_i[7:0]};
  assign wr_full  = {page_i, 1'b0, alu_i};
  assign inc_c    = fetch_addr_o + ONE;
  assign is_step  = (op_i == 3'd0) || (op_i > 3'd4);

  assert_reset_vector_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (fetch_addr_o == '1) && (lvl1 == '0) && (lvl2 == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_step |=> fetch_addr_o == $past(inc_c));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1) |=> fetch_addr_o == $past(jmp_full[PC_W-1:0]));

  assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2) |=> fetch_addr_o == $past(cal_full[PC_W-1:0]));

  assert_lowwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3) |=> fetch_addr_o == $past(wr_full[PC_W-1:0]));

  assert_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2) |=> (lvl1 == $past(inc_c)) && (lvl2 == $past(lvl1)));

  assert_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |=> (fetch_addr_o == $past(lvl1)) && (lvl1 == $past(lvl2))
                       && $stable(lvl2));

  assert_wreg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wreg_we_o |-> (op_i == 3'd4) && (wreg_lit_o == lit_i[7:0]));

endmodule

bind pcu_top pcu_top_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_i         (op_i),
  .lit_i        (lit_i),
  .alu_i        (alu_i),
  .page_i       (page_i),
  .fetch_addr_o (fetch_addr_o),
  .wreg_lit_o   (wreg_lit_o),
  .wreg_we_o    (wreg_we_o),
  .lvl1         (lvl1),
  .lvl2         (lvl2)
);

// File: tb/pcu_top_test.sv
`timescale 1ns/1ps
module pcu_top_test;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [8:0]  lit_i;
  logic [7:0]  alu_i;
  logic [1:0]  page_i;
  logic [10:0] fetch_addr_o;
  logic [7:0]  wreg_lit_o;
  logic        wreg_we_o;
  logic [9:0]  fetch10;
  logic [7:0]  wl10;
  logic        we10;

  pcu_top #(.PC_W(11)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i), .alu_i(alu_i),
    .page_i(page_i), .fetch_addr_o(fetch_addr_o), .wreg_lit_o(wreg_lit_o),
    .wreg_we_o(wreg_we_o));

  pcu_top #(.PC_W(10)) uut10 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i), .alu_i(alu_i),
    .page_i(page_i), .fetch_addr_o(fetch10), .wreg_lit_o(wl10),
    .wreg_we_o(we10));

  typedef struct {
    logic [10:0] pc;
    logic        we;
    logic [7:0]  wl;
    logic        chk10;
    logic [9:0]  pc10;
    string       tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [10:0] m_pc, m_s1, m_s2;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation and pushes the expected result.
  task automatic apply(input logic [2:0] op, input logic [8:0] lit,
                       input logic [7:0] alu, input logic [1:0] pg,
                       input string tag, input logic c10 = 1'b0,
                       input logic [9:0] e10 = '0);
    item_t it;
    logic [10:0] nxt;
    @(negedge clk);
    op_i = op; lit_i = lit; alu_i = alu; page_i = pg;
    case (op)
      3'd1: nxt = {pg, lit};
      3'd2: begin nxt = {pg, 1'b0, lit[7:0]}; m_s2 = m_s1; m_s1 = m_pc + 11'd1; end
      3'd3: nxt = {pg, 1'b0, alu};
      3'd4: begin nxt = m_s1; m_s1 = m_s2; end
      default: nxt = m_pc + 11'd1;
    endcase
    m_pc = nxt;
    it.pc = nxt; it.we = (op == 3'd4); it.wl = lit[7:0];
    it.chk10 = c10; it.pc10 = e10; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares after each rising edge, while inputs are still held.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " addr"}, 32'(fetch_addr_o), 32'(it.pc));
        check("R10 we", 32'(wreg_we_o), 32'(it.we));
        if (it.we) check("R10 literal", 32'(wreg_lit_o), 32'(it.wl));
        if (it.chk10) check("R11 10-bit addr", 32'(fetch10), 32'(it.pc10));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_i = 3'd0; lit_i = '0; alu_i = '0; page_i = '0;
    m_pc = 11'h7FF; m_s1 = '0; m_s2 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset vector", 32'(fetch_addr_o), 32'h7FF);
    check("R1 reset vector 10-bit", 32'(fetch10), 32'h3FF);
    @(posedge clk); #1 rst_n = 1'b1;

    apply(3'd0, 9'h000, 8'h00, 2'd0, "R2 wrap to zero");
    apply(3'd4, 9'h0A5, 8'h00, 2'd0, "R1 return from cleared stack");
    apply(3'd1, 9'h1FF, 8'h00, 2'd0, "R3 jump");
    apply(3'd0, 9'h000, 8'h00, 2'd0, "R2 page carry");
    apply(3'd1, 9'h05A, 8'h00, 2'd0, "R6 jump after rollover", 1'b1, 10'h05A);
    apply(3'd1, 9'h123, 8'h00, 2'd3, "R3 jump page 3", 1'b1, 10'h323);
    apply(3'd1, 9'h0F0, 8'h00, 2'd2, "R11 jump page 2", 1'b1, 10'h0F0);
    apply(3'd7, 9'h1FF, 8'hFF, 2'd3, "R2 unused code steps");
    apply(3'd3, 9'h1FF, 8'h3C, 2'd2, "R5 low-byte write");
    apply(3'd2, 9'h1A5, 8'h00, 2'd1, "R4 call bit8 low");
    apply(3'd2, 9'h010, 8'h00, 2'd0, "R7 second call");
    apply(3'd2, 9'h077, 8'h00, 2'd3, "R8 third call");
    apply(3'd4, 9'h05A, 8'h00, 2'd0, "R9 return one");
    apply(3'd4, 9'h0C3, 8'h00, 2'd1, "R8 return two drops oldest");
    apply(3'd4, 9'h011, 8'h00, 2'd2, "R9 return three repeats");
    apply(3'd0, 9'h000, 8'h00, 2'd0, "R2 step after return");
    apply(3'd2, 9'h100, 8'h00, 2'd2, "R4 call ignores lit bit8");
    apply(3'd3, 9'h000, 8'hFF, 2'd0, "R5 write page 0");
    apply(3'd4, 9'h000, 8'h00, 2'd0, "R7 return to call site");
    apply(3'd0, 9'h000, 8'h00, 2'd0, "R2 final step");
    @(negedge clk);
    op_i = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule